// File: doc/BRIEF.md
# Time-Slotted Keyboard Scanner

This block walks a 49-key keyboard through a repeating frame of 64 time slots, one slot per scan clock. During each slot at most one key line is strobed, and the state of that key's contact appears on a serial, active-low key-data line. A downstream voice assigner can rebuild the keyboard state from this pulse train and three timing signals: a frame sync that is low for one slot at the end of each frame, a half flag that tells the lower keys apart from the upper keys for split modes, and a parity bit that flips once per frame so that the assigner can act on only every other frame.

The slot number is split into a line field (low three bits) and a group field (high bits). Group 0 carries no keys, so key 1 sits in slot 8 and key 49 in slot 56. Slots 57 to 62 are idle and slot 63 is the sync slot. At a 14.6 kHz scan clock a slot lasts about 68.5 µs, a frame about 4.4 ms, and a parity-qualified update about 8.8 ms.

Top module: `kbs_scanner`

## Requirements
- R1: A synchronous active-high reset puts the slot number at 0 and parity at 0. These values are visible on the cycle after the reset edge, and again after a reset applied in the middle of a frame.
- R2: Out of reset the slot number `slot_num` rises by one on every clock and wraps from 63 to 0.
- R3: `parity` inverts on the clock edge that wraps the slot number from 63 to 0 and holds at every other edge.
- R4: `key_strobe` is one-hot: bit k-1 is high exactly while the slot number is 7+k (key k, 1 to 49), and all bits are low in slots 0 to 7 and 57 to 63.
- R5: In slot 7+k, `key_data_n` is 0 when `key_closed[k-1]` is 1 (contact closed) and 1 when it is 0. The state of other keys has no effect in that slot.
- R6: In slots 0 to 7 and 57 to 63, `key_data_n` is 1 for any pattern on `key_closed`, including all keys closed.
- R7: `sync_n` is 0 in slot 63 only and 1 in every other slot.
- R8: `half` is 0 in slots 0 to 31 (keys 1 to 24) and 1 in slots 32 to 63 (keys 25 to 49).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; one slot per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_closed | input | 49 | Raw key contacts, bit k-1 = key k, 1 = closed |
| key_strobe | output | 49 | One-hot key line drive, bit k-1 high during key k's slot |
| key_data_n | output | 1 | Serial key data, low in the slot of a closed key |
| sync_n | output | 1 | Frame sync, low during slot 63 |
| half | output | 1 | 0 while keys 1-24 are scanned, 1 for keys 25-49 and the tail |
| parity | output | 1 | Frame parity, flips at each frame wrap |
| slot_num | output | 6 | Current slot number |

## Verification
The frame boundary is the place where functions meet. The edge that leaves the sync slot also flips parity, drops the half flag and wraps the slot number, so a single edge can get any of them wrong. The bench sweeps whole frames one slot at a time with several key patterns, all keys closed among them, and compares every output in every slot with values worked out from the cycle count. It also applies a reset while the sync slot is active, then requires slot 0, parity 0 and a released sync on the next cycle.

// File: rtl/kbs_pkg.sv
package kbs_pkg;

   // Slot-field geometry shared by the scanner submodules.
   function automatic int kbs_slots(input int slot_bits);
      return 1 << slot_bits;
   endfunction

   // Slot index that carries a given zero-based key.
   function automatic int kbs_key_slot(input int first_slot, input int key_idx);
      return first_slot + key_idx;
   endfunction

   // True when the value is an exact power of two.
   function automatic bit kbs_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/kbs_slot_counter.sv
module kbs_slot_counter #(
   parameter int SLOT_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   output logic [SLOT_BITS-1:0] slot_o,
   output logic                 parity_o
);
   localparam int CNT_W = SLOT_BITS + 1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   // Parity is the carry bit above the slot field, so it flips on each wrap.
   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + ONE;
   end

   assign slot_o   = cnt_q[SLOT_BITS-1:0];
   assign parity_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/kbs_line_decoder.sv
module kbs_line_decoder #(
   parameter int NUM_KEYS       = 49,
   parameter int SLOT_BITS      = 6,
   parameter int LINE_BITS      = 3,
   parameter int FIRST_KEY_SLOT = 8
) (
   input  logic [SLOT_BITS-1:0] slot_i,
   output logic [NUM_KEYS-1:0]  strobe_o
);
   import kbs_pkg::*;
   localparam int GROUP_BITS = SLOT_BITS - LINE_BITS;

   logic [GROUP_BITS-1:0] grp_field;
   logic [LINE_BITS-1:0]  line_field;
   assign grp_field  = slot_i[SLOT_BITS-1:LINE_BITS];
   assign line_field = slot_i[LINE_BITS-1:0];

   // Two-level select: a group match enables the line match within it.
   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      localparam int KSLOT = kbs_key_slot(FIRST_KEY_SLOT, k);
      localparam logic [GROUP_BITS-1:0] KGRP  = GROUP_BITS'(KSLOT >> LINE_BITS);
      localparam logic [LINE_BITS-1:0]  KLINE = LINE_BITS'(KSLOT % (1 << LINE_BITS));
      logic grp_hit;
      assign grp_hit     = (grp_field == KGRP);
      assign strobe_o[k] = grp_hit && (line_field == KLINE);
   end
endmodule

// File: rtl/kbs_key_mux.sv
module kbs_key_mux #(
   parameter int NUM_KEYS = 49
) (
   input  logic [NUM_KEYS-1:0] strobe_i,
   input  logic [NUM_KEYS-1:0] keys_i,
   output logic                data_n_o
);
   // Only the strobed contact reaches the serial line; idle slots stay high.
   logic [NUM_KEYS-1:0] hit;
   assign hit      = strobe_i & keys_i;
   assign data_n_o = ~(|hit);
endmodule

// File: rtl/kbs_frame_timing.sv
module kbs_frame_timing #(
   parameter int SLOT_BITS  = 6,
   parameter int SPLIT_SLOT = 32
) (
   input  logic [SLOT_BITS-1:0] slot_i,
   output logic                 sync_n_o,
   output logic                 half_o
);
   import kbs_pkg::*;
   localparam int MID_SLOT = 1 << (SLOT_BITS - 1);
   localparam logic [SLOT_BITS-1:0] SYNC_SLOT = '1;

   assign sync_n_o = (slot_i != SYNC_SLOT);

   // Split at the frame midpoint taps the slot MSB; any other point compares.
   if (SPLIT_SLOT == MID_SLOT) begin : g_half_tap
      assign half_o = slot_i[SLOT_BITS-1];
   end else begin : g_half_cmp
      localparam logic [SLOT_BITS-1:0] SPLIT_V = SLOT_BITS'(SPLIT_SLOT);
      assign half_o = (slot_i >= SPLIT_V);
   end
endmodule

// File: rtl/kbs_scanner.sv
module kbs_scanner #(
   parameter int NUM_KEYS       = 49,
   parameter int SLOT_BITS      = 6,
   parameter int LINE_BITS      = 3,
   parameter int FIRST_KEY_SLOT = 8,
   parameter int SPLIT_KEY      = 24
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_KEYS-1:0]  key_closed,
   output logic [NUM_KEYS-1:0]  key_strobe,
   output logic                 key_data_n,
   output logic                 sync_n,
   output logic                 half,
   output logic                 parity,
   output logic [SLOT_BITS-1:0] slot_num
);
   import kbs_pkg::*;
   localparam int NUM_SLOTS  = kbs_slots(SLOT_BITS);
   localparam int LAST_KEY   = FIRST_KEY_SLOT + NUM_KEYS - 1;
   localparam int SPLIT_SLOT = FIRST_KEY_SLOT + SPLIT_KEY;

   // Elaboration-time parameter checks.
   if (LINE_BITS < 1 || LINE_BITS >= SLOT_BITS) begin : g_bad_line
      $error("kbs_scanner: LINE_BITS must lie in 1..SLOT_BITS-1");
   end
   if (FIRST_KEY_SLOT < 0 || LAST_KEY >= NUM_SLOTS - 1) begin : g_bad_span
      $error("kbs_scanner: keys must fit below the sync slot");
   end
   if (SPLIT_KEY < 1 || SPLIT_KEY >= NUM_KEYS) begin : g_bad_split
      $error("kbs_scanner: SPLIT_KEY must lie in 1..NUM_KEYS-1");
   end

   logic [SLOT_BITS-1:0] slot_w;
   logic                 par_w;

   kbs_slot_counter #(.SLOT_BITS(SLOT_BITS)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .slot_o   (slot_w),
      .parity_o (par_w)
   );

   kbs_line_decoder #(
      .NUM_KEYS       (NUM_KEYS),
      .SLOT_BITS      (SLOT_BITS),
      .LINE_BITS      (LINE_BITS),
      .FIRST_KEY_SLOT (FIRST_KEY_SLOT)
   ) u_dec (
      .slot_i   (slot_w),
      .strobe_o (key_strobe)
   );

   kbs_key_mux #(.NUM_KEYS(NUM_KEYS)) u_mux (
      .strobe_i (key_strobe),
      .keys_i   (key_closed),
      .data_n_o (key_data_n)
   );

   kbs_frame_timing #(
      .SLOT_BITS  (SLOT_BITS),
      .SPLIT_SLOT (SPLIT_SLOT)
   ) u_tim (
      .slot_i   (slot_w),
      .sync_n_o (sync_n),
      .half_o   (half)
   );

   assign slot_num = slot_w;
   assign parity   = par_w;
endmodule

// File: rtl/kbs_scanner_chk.sv
module kbs_scanner_chk #(
   parameter int NUM_KEYS       = 49,
   parameter int SLOT_BITS      = 6,
   parameter int FIRST_KEY_SLOT = 8,
   parameter int SPLIT_KEY      = 24
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_KEYS-1:0]  key_strobe,
   input logic                 key_data_n,
   input logic                 sync_n,
   input logic                 half,
   input logic                 parity,
   input logic [SLOT_BITS-1:0] slot_num
);
   localparam logic [SLOT_BITS-1:0] LAST_S  = '1;
   localparam logic [SLOT_BITS-1:0] ONE_S   = SLOT_BITS'(1);
   localparam logic [SLOT_BITS-1:0] FIRST_S = SLOT_BITS'(FIRST_KEY_SLOT);
   localparam logic [SLOT_BITS-1:0] LASTK_S = SLOT_BITS'(FIRST_KEY_SLOT + NUM_KEYS - 1);
   localparam logic [SLOT_BITS-1:0] SPLIT_S = SLOT_BITS'(FIRST_KEY_SLOT + SPLIT_KEY);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (slot_num == '0) && !parity);

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> slot_num == $past(slot_num) + ONE_S);

   // R3
   parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(slot_num) == LAST_S) |-> parity != $past(parity));

   // R3
   parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(slot_num) != LAST_S) |-> $stable(parity));

   // R4
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(key_strobe));

   // R4
   strobe_span_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_num < FIRST_S || slot_num > LASTK_S) |-> key_strobe == '0);

   // R6
   idle_data_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_num < FIRST_S || slot_num > LASTK_S) |-> key_data_n);

   // R7
   sync_slot_chk: assert property (@(posedge clk) disable iff (rst)
      !sync_n == (slot_num == LAST_S));

   // R8
   half_split_chk: assert property (@(posedge clk) disable iff (rst)
      half == (slot_num >= SPLIT_S));
endmodule

bind kbs_scanner kbs_scanner_chk #(
   .NUM_KEYS       (NUM_KEYS),
   .SLOT_BITS      (SLOT_BITS),
   .FIRST_KEY_SLOT (FIRST_KEY_SLOT),
   .SPLIT_KEY      (SPLIT_KEY)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .key_strobe (key_strobe),
   .key_data_n (key_data_n),
   .sync_n     (sync_n),
   .half       (half),
   .parity     (parity),
   .slot_num   (slot_num)
);

// File: tb/test_kbs_scanner.sv
`timescale 1ns/1ps
module test_kbs_scanner;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [48:0] key_closed = '0;
   logic [48:0] key_strobe;
   logic        key_data_n, sync_n, half, parity;
   logic [5:0]  slot_num;

   int total = 0;
   int fails = 0;
   int n = 0;   // cycles since last reset release
   bit done = 1'b0;

   always #5 clk = ~clk;

   kbs_scanner i_kbs_scanner (
      .clk(clk), .rst(rst), .key_closed(key_closed), .key_strobe(key_strobe),
      .key_data_n(key_data_n), .sync_n(sync_n), .half(half),
      .parity(parity), .slot_num(slot_num)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, n);
      end
   endtask

   task automatic check_slot();
      int s = n % 64;
      int p = (n / 64) % 2;
      bit in_keys = (s >= 8) && (s <= 56);
      logic [48:0] exp_str = in_keys ? (49'b1 << (s - 8)) : 49'b0;
      bit exp_kd = in_keys ? !key_closed[s - 8] : 1'b1;
      chk(slot_num == 6'(s), "R2 slot_num", slot_num, s);
      chk(parity == p[0], "R3 parity", parity, p);
      chk(key_strobe == exp_str, "R4 key_strobe", key_strobe, exp_str);
      if (in_keys) chk(key_data_n == exp_kd, "R5 key_data_n", key_data_n, exp_kd);
      else         chk(key_data_n == 1'b1,   "R6 key_data_n idle", key_data_n, 1);
      chk(sync_n == (s != 63), "R7 sync_n", sync_n, (s != 63));
      chk(half == (s >= 32), "R8 half", half, (s >= 32));
   endtask

   task automatic run_frames(input logic [48:0] pat, input int cycles);
      key_closed = pat;
      for (int c = 0; c < cycles; c++) begin
         check_slot();
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      n = 0;
      // R1: state right after reset
      chk(slot_num == 6'd0, "R1 slot after reset", slot_num, 0);
      chk(parity == 1'b0, "R1 parity after reset", parity, 0);

      run_frames(49'h0, 128);
      run_frames('1, 128);                         // all closed, idle slots still high
      run_frames(49'h0_AAAA_AAAA_AAAA, 128);
      run_frames(49'h1_5555_5555_5555, 128);
      run_frames(49'h1, 64);                       // key 1 only
      run_frames(49'h1_0000_0000_0000, 64);        // key 49 only
      run_frames(49'h0_0000_0180_0000, 128);       // keys 24 and 25 at split

      // Reset while sync slot is active (R1 with R7 and R3 at the wrap)
      while (n % 64 != 63) begin
         check_slot();
         @(negedge clk);
         n++;
      end
      chk(sync_n == 1'b0, "R7 sync before reset", sync_n, 0);
      rst = 1'b1;
      @(negedge clk);
      chk(slot_num == 6'd0, "R1 slot after mid-frame reset", slot_num, 0);
      chk(parity == 1'b0, "R1 parity after mid-frame reset", parity, 0);
      chk(sync_n == 1'b1, "R7 sync released by reset", sync_n, 1);
      @(negedge clk);
      chk(slot_num == 6'd0, "R1 slot held in reset", slot_num, 0);
      rst = 1'b0;
      n = 0;
      run_frames(49'h0_0F0F_F0F0_0F0F, 128);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule